// File: doc/BRIEF.md
# Programmable Almost-Full / Almost-Empty Flag Generator

This block watches the fill level of a dual-clock FIFO and drives two early-warning flags. The flags are almost-full and almost-empty. Each flag is compared against its own offset register. The FIFO's storage and pointers sit outside the block. The block only receives the occupancy count as seen in each clock domain: `wr_count` is already synchronised into the write clock domain, and `rd_count` into the read clock domain.

The two offsets are set when the block leaves master reset. Each one takes one of eight preset values, chosen by a three-bit selector. Software can later overwrite the offsets in two ways. The first is a serial stream, one bit per write clock. The second is a parallel load that reuses the data bus, a slice at a time. The same slices can be read back in parallel on the read clock. Partial reset restarts the load and readback sequencing but keeps the programmed offsets.

A mode input sets the flag timing. In synchronous mode, each flag is a plain register in its own domain. In asynchronous mode, a flag is raised by the clock whose traffic caused the condition. It is lowered by the opposite clock once that side's count shows the condition is gone.

Top module: `prog_level_flags`

## Requirements
- R1: While `mrst` or `prst` is high, the next clock edge leaves `almost_empty` = 1 and `almost_full` = 0, whatever the counts.
- R2: On master reset, both offsets load `(8 << k) - 1`, where k = {`ld`,`fsel[1]`,`fsel[0]`} as a 3-bit number. With the default parameters, the selector 3'b010 gives 31 and 3'b111 gives 1023.
- R3: In synchronous mode, `almost_empty` is 1 one read-clock edge after `rd_count` <= empty offset, and 0 otherwise.
- R4: In synchronous mode, `almost_full` is 1 one write-clock edge after DEPTH - `wr_count` <= full offset, and 0 otherwise.
- R5: A write-clock edge with `ld`=1 and `wen`=1 writes `din` into one DW-bit slice, in this order: empty offset slices from least significant upward, then full offset slices the same way. With the defaults, each offset has two 9-bit slices. Parallel load takes priority over serial load.
- R6: A read-clock edge with `ld`=1 and `ren`=1 places the next slice, in the same order, on `rb_data`. This readback uses its own index.
- R7: Both slice indexes wrap to the first slice after the last one.
- R8: Partial reset keeps both offsets. It restarts the parallel write index, the readback index and the serial bit count.
- R9: On each write-clock edge with `sen`=1 (and no parallel load), `ser_in` is stored as the next offset bit. The first OW bits go to the empty offset, least significant bit first. The next OW bits go to the full offset in the same way, and then the count wraps.
- R10: In asynchronous mode, `almost_full` rises on the write-clock edge that sees the write-side count hit the threshold. It falls on a read-clock edge that sees the read-side count clear of the threshold.
- R11: In asynchronous mode, `almost_empty` rises on the read-clock edge that sees the read-side count hit the threshold. It falls on a write-clock edge that sees the write-side count clear of the threshold.
- R12: In synchronous mode, each flag follows only its own domain's count and ignores the opposite count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| mrst | input | 1 | Master reset, synchronous, active high; loads the preset offsets |
| prst | input | 1 | Partial reset, synchronous, active high; keeps the offsets |
| sync_mode | input | 1 | 1 = synchronous flag timing, 0 = asynchronous flag timing |
| fsel | input | 2 | Preset selector, low two bits |
| ld | input | 1 | Load / readback qualifier; also the high preset selector bit |
| wen | input | 1 | Parallel write strobe (with `ld`) |
| ren | input | 1 | Parallel readback strobe (with `ld`) |
| sen | input | 1 | Serial load enable |
| ser_in | input | 1 | Serial offset bit |
| din | input | DW | Parallel offset slice |
| wr_count | input | $clog2(DEPTH)+1 | Occupancy as seen in the write domain |
| rd_count | input | $clog2(DEPTH)+1 | Occupancy as seen in the read domain |
| almost_full | output | 1 | Almost-full flag |
| almost_empty | output | 1 | Almost-empty flag |
| rb_data | output | DW | Offset slice read back |

## Verification
The bench drives occupancy exactly at each threshold and one step beyond it. A comparison using strict less-than, or one measuring used space instead of free space for almost-full, shows up there as a flag that is off by one count.

The parallel path writes one extra slice after the last one, and reads back after a partial reset. A slice index that does not wrap, or is not restarted, lands the new byte in the full offset, or returns the wrong slice.

The serial path is loaded with asymmetric values. If the bit order is reversed, or the two offsets are swapped, the thresholds move by hundreds of counts. The read-side and write-side counts are then pulled apart in both timing modes. A design that mixed up the modes would either hold a flag that asynchronous mode must drop, or drop one that synchronous mode must hold.

// File: rtl/pfg_pkg.sv
package pfg_pkg;

  // Number of reset-time presets selectable by {ld, fsel}.
  localparam int NPRESET = 8;

  // Preset offset for selector k: 7, 15, 31, ... (8 << k) - 1.
  function automatic logic [31:0] preset_ofs(input logic [2:0] sel);
    return (32'd8 << sel) - 32'd1;
  endfunction

endpackage

// File: rtl/pfg_offsets.sv
module pfg_offsets #(
  parameter int DEPTH = 1024,
  parameter int DW    = 9
) (
  input  logic                       wclk,
  input  logic                       rclk,
  input  logic                       mrst,
  input  logic                       prst,
  input  logic [1:0]                 fsel,
  input  logic                       ld,
  input  logic                       wen,
  input  logic                       ren,
  input  logic                       sen,
  input  logic                       ser_in,
  input  logic [DW-1:0]              din,
  output logic [$clog2(DEPTH)-1:0]   empty_ofs,
  output logic [$clog2(DEPTH)-1:0]   full_ofs,
  output logic [DW-1:0]              rb_data
);
  localparam int OW    = $clog2(DEPTH);
  localparam int NPART = (OW + DW - 1) / DW;
  localparam int PW    = NPART * DW;
  localparam int NSLOT = 2 * NPART;
  localparam int IW    = (NSLOT > 1) ? $clog2(NSLOT) : 1;
  localparam int NBIT  = 2 * OW;
  localparam int SW    = $clog2(NBIT);

  logic [PW-1:0] e_q, f_q;   // offsets padded to whole slices
  logic [IW-1:0] widx, ridx;
  logic [SW-1:0] sbit;
  logic [DW-1:0] rb_mux;
  logic [2:0]    psel;
  logic          pwr;

  assign psel = {ld, fsel};
  assign pwr  = ld & wen;

  // Write domain: presets, parallel slices, serial bits.
  always_ff @(posedge wclk) begin
    if (mrst) begin
      e_q  <= PW'(pfg_pkg::preset_ofs(psel));
      f_q  <= PW'(pfg_pkg::preset_ofs(psel));
      widx <= '0;
      sbit <= '0;
    end else if (prst) begin
      widx <= '0;
      sbit <= '0;
    end else if (pwr) begin
      for (int p = 0; p < NPART; p++) begin
        if (widx == IW'(p))         e_q[p*DW +: DW] <= din;
        if (widx == IW'(p + NPART)) f_q[p*DW +: DW] <= din;
      end
      widx <= (widx == IW'(NSLOT - 1)) ? '0 : widx + 1'b1;
    end else if (sen) begin
      for (int b = 0; b < OW; b++) begin
        if (sbit == SW'(b))      e_q[b] <= ser_in;
        if (sbit == SW'(b + OW)) f_q[b] <= ser_in;
      end
      sbit <= (sbit == SW'(NBIT - 1)) ? '0 : sbit + 1'b1;
    end
  end

  // Readback slice select.
  always_comb begin
    rb_mux = '0;
    for (int p = 0; p < NPART; p++) begin
      if (ridx == IW'(p))         rb_mux = e_q[p*DW +: DW];
      if (ridx == IW'(p + NPART)) rb_mux = f_q[p*DW +: DW];
    end
  end

  // Read domain: registered readback.
  always_ff @(posedge rclk) begin
    if (mrst || prst) begin
      ridx    <= '0;
      rb_data <= '0;
    end else if (ld && ren) begin
      rb_data <= rb_mux;
      ridx    <= (ridx == IW'(NSLOT - 1)) ? '0 : ridx + 1'b1;
    end
  end

  assign empty_ofs = e_q[OW-1:0];
  assign full_ofs  = f_q[OW-1:0];

  assert_preset_R2: assert property (@(posedge wclk)
    mrst |=> (empty_ofs == OW'(pfg_pkg::preset_ofs($past(psel))) &&
              full_ofs  == OW'(pfg_pkg::preset_ofs($past(psel)))));

  assert_keep_R8: assert property (@(posedge wclk) disable iff (mrst)
    prst |=> ($stable(e_q) && $stable(f_q)));

  assert_widx_wrap_R7: assert property (@(posedge wclk) disable iff (mrst)
    (pwr && !prst && widx == IW'(NSLOT - 1)) |=> (widx == '0));

  assert_sbit_range_R9: assert property (@(posedge wclk) disable iff (mrst)
    (sbit <= SW'(NBIT - 1)));

endmodule

// File: rtl/pfg_flag.sv
module pfg_flag #(
  parameter int DEPTH    = 1024,
  parameter bit USE_FREE = 1'b0,
  parameter bit RST_VAL  = 1'b0
) (
  input  logic                      own_clk,
  input  logic                      opp_clk,
  input  logic                      rst,
  input  logic                      sync_mode,
  input  logic [$clog2(DEPTH):0]    own_cnt,
  input  logic [$clog2(DEPTH):0]    opp_cnt,
  input  logic [$clog2(DEPTH)-1:0]  ofs,
  output logic                      flag
);
  localparam int OW = $clog2(DEPTH);
  localparam int CW = OW + 1;

  // Threshold test on either occupancy or free space.
  function automatic logic hits(input logic [CW-1:0] cnt, input logic [OW-1:0] o);
    logic [CW-1:0] m;
    m = USE_FREE ? (CW'(DEPTH) - cnt) : cnt;
    return m <= {1'b0, o};
  endfunction

  logic own_hit, opp_hit;
  logic lvl_q;          // synchronous-mode flag
  logic set_t, clr_t;   // toggle pair for asynchronous mode
  logic async_q;

  assign own_hit = hits(own_cnt, ofs);
  assign opp_hit = hits(opp_cnt, ofs);
  assign async_q = set_t ^ clr_t;

  always_ff @(posedge own_clk) begin
    if (rst) lvl_q <= RST_VAL;
    else     lvl_q <= own_hit;
  end

  // Raise on the owning clock.
  always_ff @(posedge own_clk) begin
    if (rst)                      set_t <= RST_VAL;
    else if (own_hit && !async_q) set_t <= ~set_t;
  end

  // Lower on the opposite clock.
  always_ff @(posedge opp_clk) begin
    if (rst)                     clr_t <= 1'b0;
    else if (!opp_hit && async_q) clr_t <= ~clr_t;
  end

  assign flag = sync_mode ? lvl_q : async_q;

  assert_reset_R1: assert property (@(posedge own_clk)
    rst |=> (flag == RST_VAL));

  assert_sync_set_R12: assert property (@(posedge own_clk) disable iff (rst)
    (sync_mode && own_hit) |=> (flag || !sync_mode));

  assert_sync_clear_R12: assert property (@(posedge own_clk) disable iff (rst)
    (sync_mode && !own_hit) |=> (!flag || !sync_mode));

  // Raising side of asynchronous timing (also covers R11 for almost-empty).
  assert_async_set_R10: assert property (@(posedge own_clk) disable iff (rst)
    (!sync_mode && own_hit && !async_q) |=> (set_t != $past(set_t)));

  // Lowering side of asynchronous timing (also covers R10 for almost-full).
  assert_async_clr_R11: assert property (@(posedge opp_clk) disable iff (rst)
    (!sync_mode && !opp_hit && async_q) |=> (clr_t != $past(clr_t)));

endmodule

// File: rtl/prog_level_flags.sv
module prog_level_flags #(
  parameter int DEPTH = 1024,
  parameter int DW    = 9
) (
  input  logic                     wclk,
  input  logic                     rclk,
  input  logic                     mrst,
  input  logic                     prst,
  input  logic                     sync_mode,
  input  logic [1:0]               fsel,
  input  logic                     ld,
  input  logic                     wen,
  input  logic                     ren,
  input  logic                     sen,
  input  logic                     ser_in,
  input  logic [DW-1:0]            din,
  input  logic [$clog2(DEPTH):0]   wr_count,
  input  logic [$clog2(DEPTH):0]   rd_count,
  output logic                     almost_full,
  output logic                     almost_empty,
  output logic [DW-1:0]            rb_data
);
  localparam int OW = $clog2(DEPTH);

  logic [OW-1:0] empty_ofs, full_ofs;
  logic          any_rst;

  assign any_rst = mrst | prst;

  pfg_offsets #(.DEPTH(DEPTH), .DW(DW)) u_offsets (
    .wclk(wclk), .rclk(rclk), .mrst(mrst), .prst(prst),
    .fsel(fsel), .ld(ld), .wen(wen), .ren(ren),
    .sen(sen), .ser_in(ser_in), .din(din),
    .empty_ofs(empty_ofs), .full_ofs(full_ofs), .rb_data(rb_data)
  );

  pfg_flag #(.DEPTH(DEPTH), .USE_FREE(1'b1), .RST_VAL(1'b0)) u_full (
    .own_clk(wclk), .opp_clk(rclk), .rst(any_rst), .sync_mode(sync_mode),
    .own_cnt(wr_count), .opp_cnt(rd_count), .ofs(full_ofs), .flag(almost_full)
  );

  pfg_flag #(.DEPTH(DEPTH), .USE_FREE(1'b0), .RST_VAL(1'b1)) u_empty (
    .own_clk(rclk), .opp_clk(wclk), .rst(any_rst), .sync_mode(sync_mode),
    .own_cnt(rd_count), .opp_cnt(wr_count), .ofs(empty_ofs), .flag(almost_empty)
  );

endmodule

// File: tb/prog_level_flags_bench.sv
module prog_level_flags_bench;
  localparam int DEPTH = 1024;
  localparam int DW    = 9;
  localparam int CW    = $clog2(DEPTH) + 1;

  logic clk = 1'b0;
  logic mrst, prst, sync_mode, ld, wen, ren, sen, ser_in;
  logic [1:0] fsel;
  logic [DW-1:0] din;
  logic [CW-1:0] wr_count, rd_count;
  logic almost_full, almost_empty;
  logic [DW-1:0] rb_data;

  int checks = 0;
  int fails  = 0;
  int m_e, m_f;   // bench model of the offsets

  typedef struct {
    bit caf; bit eaf; bit cae; bit eae; bit crb;
    logic [DW-1:0] erb;
    string tag;
  } exp_t;
  exp_t sb[$];
  exp_t cur;

  always #4 clk = ~clk;

  prog_level_flags #(.DEPTH(DEPTH), .DW(DW)) u_prog_level_flags (
    .wclk(clk), .rclk(clk), .mrst(mrst), .prst(prst), .sync_mode(sync_mode),
    .fsel(fsel), .ld(ld), .wen(wen), .ren(ren), .sen(sen), .ser_in(ser_in),
    .din(din), .wr_count(wr_count), .rd_count(rd_count),
    .almost_full(almost_full), .almost_empty(almost_empty), .rb_data(rb_data)
  );

  task automatic cmp(input string tag, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Monitor: pops expectations after each edge.
  always @(posedge clk) begin
    #2;
    if (sb.size() > 0) begin
      cur = sb.pop_front();
      if (cur.caf) cmp(cur.tag, "almost_full", DW'(almost_full), DW'(cur.eaf));
      if (cur.cae) cmp(cur.tag, "almost_empty", DW'(almost_empty), DW'(cur.eae));
      if (cur.crb) cmp(cur.tag, "rb_data", rb_data, cur.erb);
    end
  end

  task automatic push(input string tag, input bit caf, input bit eaf, input bit cae,
                      input bit eae, input bit crb, input logic [DW-1:0] erb);
    exp_t e;
    e.caf = caf; e.eaf = eaf; e.cae = cae; e.eae = eae; e.crb = crb; e.erb = erb; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic flags_after(input string tag, input bit caf, input bit eaf, input bit cae, input bit eae);
    push(tag, caf, eaf, cae, eae, 1'b0, '0);
    @(negedge clk);
  endtask

  task automatic rb_after(input string tag, input logic [DW-1:0] v);
    push(tag, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, v);
    @(negedge clk);
  endtask

  task automatic set_counts(input int w, input int r);
    wr_count = CW'(w);
    rd_count = CW'(r);
  endtask

  // Drive equal counts and check both flags against the model.
  task automatic occ_check(input string tag, input int occ);
    set_counts(occ, occ);
    flags_after(tag, 1'b1, ((DEPTH - occ) <= m_f), 1'b1, (occ <= m_e));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not complete, got hang expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    mrst = 1'b1; prst = 1'b0; sync_mode = 1'b1; fsel = 2'b10; ld = 1'b0;
    wen = 1'b0; ren = 1'b0; sen = 1'b0; ser_in = 1'b0; din = '0;
    set_counts(500, 500);
    idle();
    // R1: reset state regardless of counts
    flags_after("R1 master reset", 1'b1, 1'b0, 1'b1, 1'b1);
    mrst = 1'b0; m_e = 31; m_f = 31;

    // R3 / R4 thresholds with preset 31 (selector 3'b010)
    occ_check("R3 ae at offset", 31);
    occ_check("R3 ae above offset", 32);
    occ_check("R4 af at offset", 993);
    occ_check("R4 af above offset", 992);

    // R2: selector 3'b111 -> 1023
    mrst = 1'b1; ld = 1'b1; fsel = 2'b11;
    idle(); idle();
    mrst = 1'b0; ld = 1'b0; m_e = 1023; m_f = 1023;
    occ_check("R2 preset 1023 low", 1023);
    occ_check("R2 preset 1023 full", 1024);
    occ_check("R2 preset 1023 zero", 0);

    // R5: parallel load, empty lo/hi then full lo/hi
    ld = 1'b1; wen = 1'b1;
    din = 9'd5;  idle();
    din = 9'd0;  idle();
    din = 9'd64; idle();
    din = 9'd1;  idle();
    wen = 1'b0;
    m_e = 5; m_f = 576;
    // R6: readback in the same slice order
    ren = 1'b1;
    rb_after("R6 readback empty lo", 9'd5);
    rb_after("R6 readback empty hi", 9'd0);
    rb_after("R6 readback full lo", 9'd64);
    rb_after("R6 readback full hi", 9'd1);
    ren = 1'b0; ld = 1'b0;
    occ_check("R5 parallel empty at", 5);
    occ_check("R5 parallel empty above", 6);
    occ_check("R5 parallel full at", 448);
    occ_check("R5 parallel full above", 447);

    // R7: fifth write wraps to empty low slice
    ld = 1'b1; wen = 1'b1; din = 9'd9; idle();
    wen = 1'b0; ld = 1'b0; m_e = 9;
    occ_check("R7 wrap write empty at", 9);
    occ_check("R7 wrap write empty above", 10);
    occ_check("R7 wrap write full kept", 448);
    ld = 1'b1; ren = 1'b1;
    rb_after("R7 readback wrapped", 9'd9);
    ren = 1'b0; ld = 1'b0;

    // R8: partial reset keeps offsets, restarts indexes
    prst = 1'b1; set_counts(500, 500);
    flags_after("R8 R1 partial reset flags", 1'b1, 1'b0, 1'b1, 1'b1);
    prst = 1'b0;
    ld = 1'b1; ren = 1'b1;
    rb_after("R8 readback index restarted", 9'd9);
    ren = 1'b0; ld = 1'b0;
    occ_check("R8 empty offset kept", 9);
    occ_check("R8 full offset kept", 448);

    // R9: serial load, empty=3 then full=100, LSB first
    sen = 1'b1;
    for (int b = 0; b < 10; b++) begin ser_in = 1'((3 >> b) & 1); idle(); end
    for (int b = 0; b < 10; b++) begin ser_in = 1'((100 >> b) & 1); idle(); end
    sen = 1'b0; ser_in = 1'b0; m_e = 3; m_f = 100;
    occ_check("R9 serial empty at", 3);
    occ_check("R9 serial empty above", 4);
    occ_check("R9 serial full at", 924);
    occ_check("R9 serial full above", 923);

    // R12: synchronous mode ignores the opposite count
    set_counts(500, 500); idle(); idle();
    set_counts(924, 900); idle();
    flags_after("R12 sync af holds", 1'b1, 1'b1, 1'b0, 1'b0);
    set_counts(10, 2); idle();
    flags_after("R12 sync ae holds", 1'b0, 1'b0, 1'b1, 1'b1);

    // R10: asynchronous almost-full
    set_counts(500, 500); sync_mode = 1'b0; idle(); idle();
    set_counts(924, 900);
    flags_after("R10 async af rises on write side", 1'b1, 1'b1, 1'b0, 1'b0);
    flags_after("R10 async af falls on read side", 1'b1, 1'b0, 1'b0, 1'b0);

    // R11: asynchronous almost-empty
    set_counts(500, 500); idle(); idle();
    set_counts(10, 2);
    flags_after("R11 async ae rises on read side", 1'b0, 1'b0, 1'b1, 1'b1);
    flags_after("R11 async ae falls on write side", 1'b0, 1'b0, 1'b1, 1'b0);

    set_counts(500, 500);
    idle(); idle(); idle();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule